// File: doc/BRIEF.md
# Debug-Port Bus Access Unit

This unit lets a debug host, working through a scan port, reach system memory one beat at a time. The host loads an address register and, for stores, a data register. It then writes a control word that picks the direction and the access size and sets a start bit. The unit issues exactly one byte, halfword or word access on a valid/ready memory port with byte enables. It waits for the response, then clears the start bit. The host polls the start bit as a busy indicator.

Data always sits on its natural byte lanes; it is never right-justified. A load places the returned bus word in the data register exactly as it arrived. A store drives the data register onto the bus unchanged, and the byte enables mark the lanes that the low address bits and the size select. A bus error response, or a request with a misaligned address, sets a sticky error bit. Only a control write with the enable bit clear removes it.

Top module: `dbg_bus_access`

## Requirements
- R1: After reset the address, data and control registers all read as zero, and no memory request is raised.
- R2: Register select 0 is the address register, 1 is data and 2 is control; any other select reads zero. The control bits are: bit 0 enable, bit 1 read (1 = load, 0 = store), bits 3:2 size (0 byte, 1 halfword, 2 word, 3 reserved), bit 4 start and bit 5 error. A control write with enable and start both 1 issues exactly one request to the address register, with mem_we_o equal to the inverse of the read bit.
- R3: The start bit reads 1 from the cycle after the launching write until the response arrives, and reads 0 after that.
- R4: The request holds its address and byte enables until mem_gnt_i is seen. The unit then waits for mem_rvalid_i before it goes idle.
- R5: A load copies the whole returned bus word into the data register without shifting it.
- R6: The byte enables are as follows. A byte access sets only lane k, where k is address[1:0]. A halfword access sets 4'b1100 when address[1] is 1 and 4'b0011 otherwise. A word access sets 4'b1111.
- R7: A store drives the data register onto mem_wdata_o exactly as written.
- R8: A response with mem_err_i set raises the error bit. The bit stays set through later accesses that succeed.
- R9: A control write with the enable bit 0 clears the error bit and leaves the unit idle.
- R10: While an access is outstanding, writes to every register are ignored. This includes a control write that sets start.
- R11: A word access with address[1:0] not zero, a halfword access with address[0] set, or the reserved size completes at once. It sets the error bit and issues no request.
- R12: A control write with enable 1 and start 0 issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe from the scan side |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | DATA_W | Register write value |
| reg_rdata_o | output | DATA_W | Value of the selected register |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a store |
| mem_addr_o | output | ADDR_W | Request byte address |
| mem_be_o | output | DATA_W/8 | Byte lane enables |
| mem_wdata_o | output | DATA_W | Store data on natural lanes |
| mem_gnt_i | input | 1 | Request accepted (ready) |
| mem_rvalid_i | input | 1 | Response valid |
| mem_rdata_i | input | DATA_W | Load data |
| mem_err_i | input | 1 | Response carries a bus error |

## Verification
The checker assumes that the memory side answers each accepted request with exactly one mem_rvalid_i pulse, at least one cycle after the grant. It also assumes that mem_rvalid_i and mem_gnt_i are never raised when no access is in flight. The bench's responder model follows these rules. It grants only while mem_req_o is high, pulses the grant for a single cycle, and sends the response one or more cycles later. It varies the grant and response delays and injects errors only through that response pulse.

// File: rtl/dba_pkg.sv
package dba_pkg;
  localparam int SEL_W     = 2;
  localparam int CTL_EN    = 0;
  localparam int CTL_RD    = 1;
  localparam int CTL_SZ_LO = 2;
  localparam int CTL_START = 4;
  localparam int CTL_ERR   = 5;

  localparam logic [SEL_W-1:0] SEL_ADDR = 2'd0;
  localparam logic [SEL_W-1:0] SEL_DATA = 2'd1;
  localparam logic [SEL_W-1:0] SEL_CTRL = 2'd2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_RESP = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dba_lane.sv
module dba_lane
  import dba_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  xfer_size_e       size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [LANES-1:0] be_o,
  output logic             misalign_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFF_W-1:0] IDX = OFF_W'(i);
    assign be_o[i] = (size_i == SZ_BYTE) ? (off_i == IDX) :
                     (size_i == SZ_HALF) ? (off_i[OFF_W-1:1] == IDX[OFF_W-1:1]) :
                     1'b1;
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = off_i[0];
      SZ_WORD: misalign_o = |off_i;
      default: misalign_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dba_seq.sv
module dba_seq
  import dba_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic rd_i,
  input  logic mem_gnt_i,
  input  logic mem_rvalid_i,
  input  logic mem_err_i,
  output logic busy_o,
  output logic mem_req_o,
  output logic load_o,
  output logic fault_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (launch_i) state_d = SEQ_REQ;
      SEQ_REQ:  if (mem_gnt_i) state_d = SEQ_RESP;
      SEQ_RESP: if (mem_rvalid_i) state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  wire resp_now = (state_q == SEQ_RESP) && mem_rvalid_i;

  assign busy_o    = (state_q != SEQ_IDLE);
  assign mem_req_o = (state_q == SEQ_REQ);
  assign load_o    = resp_now && rd_i && !mem_err_i;
  assign fault_o   = resp_now && mem_err_i;
endmodule

// File: rtl/dba_regs.sv
module dba_regs
  import dba_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              misalign_i,
  input  logic              load_i,
  input  logic              fault_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              rd_o,
  output xfer_size_e        size_sel_o,
  output logic              err_o,
  output logic              launch_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              en_q, rd_q, err_q;
  xfer_size_e        size_q;

  // writes are accepted only while no access is in flight
  wire        wr_ok   = wr_i && !busy_i;
  wire        ctrl_wr = wr_ok && (sel_i == SEL_CTRL);
  wire        go_req  = ctrl_wr && wdata_i[CTL_EN] && wdata_i[CTL_START];
  xfer_size_e size_new;

  assign size_new   = xfer_size_e'(wdata_i[CTL_SZ_LO +: 2]);
  assign size_sel_o = ctrl_wr ? size_new : size_q;
  assign launch_o   = go_req && !misalign_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      en_q   <= 1'b0;
      rd_q   <= 1'b0;
      size_q <= SZ_BYTE;
      err_q  <= 1'b0;
    end else begin
      if (wr_ok && sel_i == SEL_ADDR) addr_q <= wdata_i[ADDR_W-1:0];
      if (load_i)                          data_q <= bus_rdata_i;
      else if (wr_ok && sel_i == SEL_DATA) data_q <= wdata_i;
      if (ctrl_wr) begin
        en_q   <= wdata_i[CTL_EN];
        rd_q   <= wdata_i[CTL_RD];
        size_q <= size_new;
      end
      if (ctrl_wr && !wdata_i[CTL_EN])             err_q <= 1'b0;
      else if ((go_req && misalign_i) || fault_i) err_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_ADDR: rdata_o[ADDR_W-1:0] = addr_q;
      SEL_DATA: rdata_o = data_q;
      SEL_CTRL: begin
        rdata_o[CTL_EN]            = en_q;
        rdata_o[CTL_RD]            = rd_q;
        rdata_o[CTL_SZ_LO +: 2]    = size_q;
        rdata_o[CTL_START]         = busy_i;
        rdata_o[CTL_ERR]           = err_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
  assign rd_o   = rd_q;
  assign err_o  = err_q;
endmodule

// File: rtl/dbg_bus_access.sv
module dbg_bus_access
  import dba_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_err_i
);
  logic              busy, misalign, load, fault, launch, rd, err;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  xfer_size_e        size_sel;

  dba_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .sel_i       (reg_sel_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .busy_i      (busy),
    .misalign_i  (misalign),
    .load_i      (load),
    .fault_i     (fault),
    .bus_rdata_i (mem_rdata_i),
    .addr_o      (addr),
    .data_o      (data),
    .rd_o        (rd),
    .size_sel_o  (size_sel),
    .err_o       (err),
    .launch_o    (launch)
  );

  dba_lane #(.DATA_W(DATA_W)) u_lane (
    .size_i     (size_sel),
    .off_i      (addr[OFF_W-1:0]),
    .be_o       (mem_be_o),
    .misalign_o (misalign)
  );

  dba_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_i     (launch),
    .rd_i         (rd),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_err_i    (mem_err_i),
    .busy_o       (busy),
    .mem_req_o    (mem_req_o),
    .load_o       (load),
    .fault_o      (fault)
  );

  assign mem_we_o    = !rd;
  assign mem_addr_o  = addr;
  assign mem_wdata_o = data;
endmodule

// File: rtl/dba_checker.sv
module dba_checker #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_gnt_i,
  input logic              mem_rvalid_i,
  input logic              mem_err_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [LANES-1:0]  mem_be_o,
  input logic              busy,
  input logic              err
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_be_o)); // R4
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy); // R3
  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !mem_req_o && mem_rvalid_i |=> !busy); // R3
  AST_BUSERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !mem_req_o && mem_rvalid_i && mem_err_i |=> err); // R8
  AST_ERR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err && busy |=> err); // R8
  AST_LANE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2
                   || $countones(mem_be_o) == LANES)); // R6
  AST_WORD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && ($countones(mem_be_o) == LANES) |-> mem_addr_o[1:0] == 2'b00); // R11
endmodule

bind dbg_bus_access dba_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dba_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_req_o    (mem_req_o),
  .mem_gnt_i    (mem_gnt_i),
  .mem_rvalid_i (mem_rvalid_i),
  .mem_err_i    (mem_err_i),
  .mem_addr_o   (mem_addr_o),
  .mem_be_o     (mem_be_o),
  .busy         (busy),
  .err          (err)
);

// File: tb/dbg_bus_access_test.sv
module dbg_bus_access_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_gnt = 1'b0, mem_rvalid = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0, n_fail = 0, n_acc = 0;
  int gnt_dly = 0, rsp_dly = 0;
  logic        rsp_err = 1'b0;
  logic [31:0] rsp_word = '0;

  typedef struct {
    logic [31:0] a;
    logic        we;
    logic [3:0]  be;
    logic [31:0] d;
  } xfer_t;
  xfer_t exp_q[$];

  always #4 clk = ~clk;

  dbg_bus_access uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .mem_err_i(mem_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(bit en, bit rd, logic [1:0] sz, bit st);
    return {26'd0, 1'b0, st, sz, rd, en};
  endfunction

  function automatic logic [3:0] lanes(logic [1:0] sz, logic [1:0] off);
    case (sz)
      2'd0:    return 4'b0001 << off;
      2'd1:    return off[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic reg_write(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] s, output logic [31:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      reg_read(2'd2, v);
      if (!v[4]) return;
      @(negedge clk);
    end
    chk(1'b0, {tag, " busy never cleared"}, 32'h1, 32'h0);
  endtask

  // driver: push the expected bus item, then launch
  task automatic launch(input logic [31:0] a, input bit rd, input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] v;
    xfer_t x;
    reg_write(2'd0, a);
    if (!rd) reg_write(2'd1, d);
    x.a = a; x.we = !rd; x.be = lanes(sz, a[1:0]); x.d = d;
    exp_q.push_back(x);
    reg_write(2'd2, ctl(1'b1, rd, sz, 1'b1));
    reg_read(2'd2, v);
    chk(v[4] == 1'b1, "R3 start high while outstanding", {31'd0, v[4]}, 32'h1);
  endtask

  // monitor: compare every accepted request against the queue
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (mem_req && mem_gnt) begin
        n_acc++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected request", mem_addr, 32'h0);
        end else begin
          xfer_t x;
          x = exp_q.pop_front();
          chk(mem_addr == x.a, "R2 request address", mem_addr, x.a);
          chk(mem_we == x.we, "R2 direction", {31'd0, mem_we}, {31'd0, x.we});
          chk(mem_be == x.be, "R6 byte enables", {28'd0, mem_be}, {28'd0, x.be});
          if (x.we) chk(mem_wdata == x.d, "R7 store data", mem_wdata, x.d);
        end
      end
    end
  end

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        for (int i = 0; i < gnt_dly; i++) begin
          @(negedge clk);
          if (!mem_req) chk(1'b0, "R4 request dropped before ready", 32'h0, 32'h1);
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        for (int i = 0; i < rsp_dly; i++) @(negedge clk);
        mem_rvalid = 1'b1; mem_rdata = rsp_word; mem_err = rsp_err;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_err = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int acc0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(2'd0, v); chk(v == 32'h0, "R1 address reset", v, 32'h0);
    reg_read(2'd1, v); chk(v == 32'h0, "R1 data reset", v, 32'h0);
    reg_read(2'd2, v); chk(v == 32'h0, "R1 control reset", v, 32'h0);
    chk(mem_req == 1'b0, "R1 no request", {31'd0, mem_req}, 32'h0);
    reg_read(2'd3, v); chk(v == 32'h0, "R2 unused select", v, 32'h0);

    // R2 R7 word store
    launch(32'h1000_0040, 1'b0, 2'd2, 32'hA5A5_1234);
    wait_idle("R3");
    reg_read(2'd2, v); chk(v[5:4] == 2'b00, "R3 start clear, no error", {30'd0, v[5:4]}, 32'h0);

    // R4 R5 word load with slow ready
    gnt_dly = 3; rsp_dly = 2; rsp_word = 32'hDEAD_BEEF;
    launch(32'h2000_0010, 1'b1, 2'd2, 32'h0);
    wait_idle("R4");
    reg_read(2'd1, v); chk(v == 32'hDEAD_BEEF, "R5 word load", v, 32'hDEAD_BEEF);

    // R5 R6 byte load on lane 3, unshifted
    gnt_dly = 0; rsp_dly = 0; rsp_word = 32'h1122_3344;
    launch(32'h2000_0013, 1'b1, 2'd0, 32'h0);
    wait_idle("R5");
    reg_read(2'd1, v); chk(v == 32'h1122_3344, "R5 byte load unshifted", v, 32'h1122_3344);

    // R6 R7 halfword store upper lanes, byte store lane 1, halfword load lower
    launch(32'h3000_0002, 1'b0, 2'd1, 32'h1234_5678);
    wait_idle("R7");
    launch(32'h3000_0001, 1'b0, 2'd0, 32'h0000_AB00);
    wait_idle("R6");
    rsp_word = 32'h0BAD_F00D;
    launch(32'h3000_0004, 1'b1, 2'd1, 32'h0);
    wait_idle("R6");
    reg_read(2'd1, v); chk(v == 32'h0BAD_F00D, "R5 halfword load", v, 32'h0BAD_F00D);

    // R10 writes while busy are ignored
    gnt_dly = 6; rsp_word = 32'h5555_AAAA;
    acc0 = n_acc;
    launch(32'h0000_0300, 1'b1, 2'd2, 32'h0);
    reg_write(2'd0, 32'h0000_0400);
    reg_write(2'd2, ctl(1'b1, 1'b0, 2'd0, 1'b1));
    reg_read(2'd0, v); chk(v == 32'h0000_0300, "R10 address kept while busy", v, 32'h300);
    wait_idle("R10");
    reg_read(2'd2, v); chk(v[1] == 1'b1, "R10 direction kept", {31'd0, v[1]}, 32'h1);
    repeat (4) @(negedge clk);
    chk(n_acc - acc0 == 1, "R10 exactly one request", n_acc - acc0, 32'h1);

    // R8 bus error is sticky
    gnt_dly = 0; rsp_err = 1'b1;
    launch(32'h0000_0500, 1'b1, 2'd2, 32'h0);
    wait_idle("R8");
    rsp_err = 1'b0;
    reg_read(2'd2, v); chk(v[5] == 1'b1, "R8 error raised", {31'd0, v[5]}, 32'h1);
    launch(32'h0000_0504, 1'b0, 2'd0, 32'h0000_0077);
    wait_idle("R8");
    reg_read(2'd2, v); chk(v[5] == 1'b1, "R8 error survives good access", {31'd0, v[5]}, 32'h1);

    // R9 enable-clear write clears error
    reg_write(2'd2, 32'h0);
    reg_read(2'd2, v); chk(v[5:4] == 2'b00, "R9 error cleared, idle", {30'd0, v[5:4]}, 32'h0);

    // R11 misaligned word and halfword, reserved size
    acc0 = n_acc;
    reg_write(2'd0, 32'h0000_0602);
    reg_write(2'd2, ctl(1'b1, 1'b1, 2'd2, 1'b1));
    reg_read(2'd2, v); chk(v[5:4] == 2'b10, "R11 misaligned word", {30'd0, v[5:4]}, 32'h2);
    reg_write(2'd2, 32'h0);
    reg_write(2'd0, 32'h0000_0601);
    reg_write(2'd2, ctl(1'b1, 1'b0, 2'd1, 1'b1));
    reg_read(2'd2, v); chk(v[5:4] == 2'b10, "R11 misaligned halfword", {30'd0, v[5:4]}, 32'h2);
    reg_write(2'd2, 32'h0);
    reg_write(2'd0, 32'h0000_0600);
    reg_write(2'd2, ctl(1'b1, 1'b0, 2'd3, 1'b1));
    reg_read(2'd2, v); chk(v[5:4] == 2'b10, "R11 reserved size", {30'd0, v[5:4]}, 32'h2);
    repeat (5) @(negedge clk);
    chk(mem_req == 1'b0 && n_acc == acc0, "R11 no request", n_acc - acc0, 32'h0);
    reg_write(2'd2, 32'h0);

    // R12 enable without start
    reg_write(2'd0, 32'h0000_0700);
    reg_write(2'd2, ctl(1'b1, 1'b1, 2'd2, 1'b0));
    repeat (5) @(negedge clk);
    reg_read(2'd2, v);
    chk(mem_req == 1'b0 && v[4] == 1'b0 && n_acc == acc0, "R12 no launch", {31'd0, v[4]}, 32'h0);

    chk(exp_q.size() == 0, "R2 all expected requests seen", exp_q.size(), 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule